// File: doc/BRIEF.md
# Reset and Wakeup Sequencer

This block produces the internal reset of a chip and brings the core clock back after power-down. Two things can start a reset. One is an active-low external reset pin, which passes through a run-length glitch filter. The other is a request from the watchdog. Either one holds internal reset asserted and restarts a shared wakeup timer. Reset is released only after all of the following are true:

- no reset source is active;
- the oscillator-valid flag is high;
- the timer has counted 2^WAKE_BITS cycles of a valid oscillator;
- the flash reports that it is ready.

If the flash is still settling after an aborted program or erase, this last condition holds the release back until the flash is ready.

Software sets a power-down bit by writing 1 on a simple bus port, and it can read the bit back. While the bit is set, the core clock-enable is low. Any of eight wakeup lines clears the bit and restarts the same timer. The clock-enable returns when the timer finishes. When reset is released after an external reset, the block sends a one-cycle strobe so that the boot-configuration pins are captured. Release after a reset that only the watchdog caused sends no strobe.

Top module: `rsw_reset_wake`

## Requirements
- R1: While `arst_n` is low, and at power-up, `sys_rst_o` is 1, `clk_en_o` is 0 and `pd_rdata_o` is 0. Power-up counts as an external reset.
- R2: A `wdt_rst_i` of 1 at a clock edge makes `sys_rst_o` 1 after that edge and restarts the wakeup timer.
- R3: After the two-flop synchronizer, a low on `ext_rst_n_i` lasting fewer than FILT_CYCLES consecutive cycles has no effect. A low lasting FILT_CYCLES cycles asserts reset. When the pin goes high, the filter output is deasserted on the next cycle.
- R4: `sys_rst_o` falls only after all of these hold: no source is active, the oscillator is valid, 2^WAKE_BITS valid-oscillator cycles have been counted since the last start, and `flash_rdy_i` is 1.
- R5: While the synchronized `osc_ok_i` is low, the timer count is held at zero. Counting starts again from zero when it returns.
- R6: `boot_latch_o` is a single-cycle pulse in the cycle in which `sys_rst_o` falls, and only if an external reset has occurred since the last release. A watchdog-only reset gives no pulse.
- R7: A bus write (`pd_wr_i`) with `pd_wdata_i`=1 sets the power-down bit. A write of 0 has no effect. The bit is visible on `pd_rdata_o`.
- R8: `clk_en_o` is 0 while any of the following holds: reset is asserted, power-down is set, or the timer is counting. A wakeup on any bit of `wake_i` while power-down is set clears the bit. `clk_en_o` then returns after 2^WAKE_BITS valid cycles.
- R9: A wakeup while power-down is clear does not start the timer, and `clk_en_o` stays 1.
- R10: A reset source or a wakeup takes priority over a bus write of 1 in the same cycle, and the power-down bit ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Power-on asynchronous reset, active low |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous |
| osc_ok_i | input | 1 | Oscillator-valid flag, asynchronous |
| flash_rdy_i | input | 1 | Flash initialised and high voltages settled |
| wake_i | input | N_WAKE | Wakeup requests (four external interrupts, four CAN), asynchronous |
| pd_wr_i | input | 1 | Bus write strobe for the power-down bit |
| pd_wdata_i | input | 1 | Bus write data; 1 sets power-down |
| pd_rdata_o | output | 1 | Power-down bit read-back |
| sys_rst_o | output | 1 | Internal chip reset, active high |
| clk_en_o | output | 1 | Core clock enable |
| boot_latch_o | output | 1 | One-cycle boot-pin capture strobe |

## Verification
A bus write that sets power-down can land in the same cycle as a wakeup or a watchdog request that clears it. The bench provokes this by driving the write together with a wakeup pulse while the bit is already set. It then repeats the write together with a watchdog request. A second collision is a watchdog request that arrives during a reset opened by the external pin. In that case the release must still carry the boot strobe. The reference model in the bench resolves each collision by the priority given in the requirements, and every output is compared with it on each clock.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
    typedef struct packed {
        logic rst;       // internal reset
        logic ext_flag;  // external reset seen since last release
        logic pd;        // power-down bit
        logic latch;     // boot-pin capture strobe
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{rst: 1'b1, ext_flag: 1'b1, pd: 1'b0, latch: 1'b0};
endpackage

// File: rtl/rsw_sync.sv
module rsw_sync #(
    parameter int         WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/rsw_glitch_filt.sv
module rsw_glitch_filt #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_n_i,   // synchronized, active low
    output logic active_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] run_d, run_q;
    logic          act_d, act_q;

    always_comb begin
        run_d = run_q;
        act_d = act_q;
        if (pin_n_i) begin
            run_d = '0;
            act_d = 1'b0;
        end else if (run_q == LAST) begin
            act_d = 1'b1;
        end else begin
            run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            run_q <= '0;
            act_q <= 1'b1;
        end else begin
            run_q <= run_d;
            act_q <= act_d;
        end
    end

    assign active_o = act_q;
endmodule

// File: rtl/rsw_wake_timer.sv
module rsw_wake_timer #(
    parameter int CNT_BITS = 12
) (
    input  logic clk,
    input  logic arst_n,
    input  logic start_i,
    input  logic osc_ok_i,
    output logic busy_o
);
    localparam logic [CNT_BITS-1:0] TOP = '1;

    logic [CNT_BITS-1:0] cnt_d, cnt_q;
    logic                busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (start_i) begin
            cnt_d  = '0;
            busy_d = 1'b1;
        end else if (!osc_ok_i) begin
            cnt_d  = '0;
        end else if (busy_q) begin
            if (cnt_q == TOP) busy_d = 1'b0;
            else              cnt_d  = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/rsw_reset_wake.sv
module rsw_reset_wake
    import rsw_pkg::*;
#(
    parameter int FILT_CYCLES = 4,
    parameter int WAKE_BITS   = 12,
    parameter int N_WAKE      = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              ext_rst_n_i,
    input  logic              wdt_rst_i,
    input  logic              osc_ok_i,
    input  logic              flash_rdy_i,
    input  logic [N_WAKE-1:0] wake_i,
    input  logic              pd_wr_i,
    input  logic              pd_wdata_i,
    output logic              pd_rdata_o,
    output logic              sys_rst_o,
    output logic              clk_en_o,
    output logic              boot_latch_o
);
    localparam int ASYNC_W = N_WAKE + 2;

    logic [ASYNC_W-1:0] async_raw, async_s;
    logic               ext_n_s, osc_s;
    logic [N_WAKE-1:0]  wake_s;
    logic               ext_act, tmr_busy;
    logic               src, wake_ev, release_c;
    seq_state_t         st_d, st_q;

    assign async_raw = {wake_i, osc_ok_i, ext_rst_n_i};

    rsw_sync #(.WIDTH(ASYNC_W), .RST_VAL('0)) u_sync (
        .clk(clk), .arst_n(arst_n), .d_i(async_raw), .q_o(async_s)
    );

    assign ext_n_s = async_s[0];
    assign osc_s   = async_s[1];
    assign wake_s  = async_s[ASYNC_W-1:2];

    rsw_glitch_filt #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk(clk), .arst_n(arst_n), .pin_n_i(ext_n_s), .active_o(ext_act)
    );

    rsw_wake_timer #(.CNT_BITS(WAKE_BITS)) u_tmr (
        .clk(clk), .arst_n(arst_n), .start_i(src | wake_ev),
        .osc_ok_i(osc_s), .busy_o(tmr_busy)
    );

    always_comb begin
        src       = ext_act | wdt_rst_i;
        wake_ev   = st_q.pd & (|wake_s);
        release_c = st_q.rst & ~src & ~tmr_busy & osc_s & flash_rdy_i;

        st_d       = st_q;
        st_d.latch = release_c & st_q.ext_flag;

        if (src)            st_d.rst = 1'b1;
        else if (release_c) st_d.rst = 1'b0;

        if (ext_act)        st_d.ext_flag = 1'b1;
        else if (release_c) st_d.ext_flag = 1'b0;

        if (src | st_q.rst | wake_ev)     st_d.pd = 1'b0;
        else if (pd_wr_i && pd_wdata_i)   st_d.pd = 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= SEQ_RESET;
        else         st_q <= st_d;
    end

    assign sys_rst_o    = st_q.rst;
    assign pd_rdata_o   = st_q.pd;
    assign boot_latch_o = st_q.latch;
    assign clk_en_o     = ~st_q.rst & ~st_q.pd & ~tmr_busy;
endmodule

// File: rtl/rsw_reset_wake_chk.sv
module rsw_reset_wake_chk (
    input logic clk,
    input logic arst_n,
    input logic wdt_rst_i,
    input logic flash_rdy_i,
    input logic sys_rst_o,
    input logic pd_rdata_o,
    input logic clk_en_o,
    input logic boot_latch_o
);
    assert_wdt_resets_R2: assert property (@(posedge clk) disable iff (!arst_n)
        wdt_rst_i |=> sys_rst_o);

    assert_release_needs_flash_R4: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(sys_rst_o) |-> $past(flash_rdy_i));

    assert_strobe_at_release_R6: assert property (@(posedge clk) disable iff (!arst_n)
        boot_latch_o |-> $fell(sys_rst_o));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!arst_n)
        boot_latch_o |=> !boot_latch_o);

    assert_reset_clears_pd_R10: assert property (@(posedge clk) disable iff (!arst_n)
        sys_rst_o |-> !pd_rdata_o);

    assert_clk_gated_R8: assert property (@(posedge clk) disable iff (!arst_n)
        (sys_rst_o || pd_rdata_o) |-> !clk_en_o);
endmodule

bind rsw_reset_wake rsw_reset_wake_chk u_chk (
    .clk(clk), .arst_n(arst_n), .wdt_rst_i(wdt_rst_i), .flash_rdy_i(flash_rdy_i),
    .sys_rst_o(sys_rst_o), .pd_rdata_o(pd_rdata_o), .clk_en_o(clk_en_o),
    .boot_latch_o(boot_latch_o)
);

// File: tb/rsw_reset_wake_tb.sv
module rsw_reset_wake_tb;
    localparam int FILT = 4;
    localparam int NB   = 5;
    localparam int NW   = 8;
    localparam int SPAN = 1 << NB;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic ext_n = 1'b1, wdt = 1'b0, osc = 1'b1, flash = 1'b1;
    logic [NW-1:0] wake = '0;
    logic wr = 1'b0, wdata = 1'b0;
    logic pd_o, rst_o, en_o, latch_o;

    always #4 clk = ~clk;   // 125 MHz

    rsw_reset_wake #(.FILT_CYCLES(FILT), .WAKE_BITS(NB), .N_WAKE(NW)) u_dut (
        .clk(clk), .arst_n(arst_n), .ext_rst_n_i(ext_n), .wdt_rst_i(wdt),
        .osc_ok_i(osc), .flash_rdy_i(flash), .wake_i(wake), .pd_wr_i(wr),
        .pd_wdata_i(wdata), .pd_rdata_o(pd_o), .sys_rst_o(rst_o),
        .clk_en_o(en_o), .boot_latch_o(latch_o)
    );

    int total = 0, bad = 0, cycles = 0, latches = 0;
    string phase = "R1";

    // behavioural reference: delay queues for synchronizers, integers for counters
    bit ext_q[$] = '{0, 0};
    bit osc_q[$] = '{0, 0};
    bit wk_q[$]  = '{0, 0};
    int low_run = 0, tick = 0;
    bit m_filt = 1, m_busy = 1, m_rst = 1, m_ext = 1, m_pd = 0, m_latch = 0;

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ext_q = '{0, 0}; osc_q = '{0, 0}; wk_q = '{0, 0};
            low_run = 0; tick = 0;
            m_filt = 1; m_busy = 1; m_rst = 1; m_ext = 1; m_pd = 0; m_latch = 0;
        end else begin
            bit e, o, w, src, wev, rel, nf;
            e = ext_q[0]; o = osc_q[0]; w = wk_q[0];
            src = m_filt | wdt;
            wev = m_pd & w;
            rel = m_rst & !src & !m_busy & o & flash;
            nf = m_filt;
            if (e) begin low_run = 0; nf = 0; end
            else if (low_run == FILT - 1) nf = 1;
            else low_run++;
            if (src | wev) begin tick = 0; m_busy = 1; end
            else if (!o) tick = 0;
            else if (m_busy) begin
                if (tick == SPAN - 1) m_busy = 0; else tick++;
            end
            m_latch = rel & m_ext;
            if (m_filt) m_ext = 1; else if (rel) m_ext = 0;
            if (src | m_rst | wev) m_pd = 0; else if (wr & wdata) m_pd = 1;
            if (src) m_rst = 1; else if (rel) m_rst = 0;
            m_filt = nf;
            void'(ext_q.pop_front()); ext_q.push_back(ext_n);
            void'(osc_q.pop_front()); osc_q.push_back(osc);
            void'(wk_q.pop_front());  wk_q.push_back(|wake);
        end
    end

    task automatic chk(string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk("sys_rst", rst_o, m_rst);
        chk("pd_rdata", pd_o, m_pd);
        chk("clk_en", en_o, !m_rst & !m_pd & !m_busy);
        chk("boot_latch", latch_o, m_latch);
        if (latch_o) latches++;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pd_write(bit v);
        wr = 1; wdata = v; step(1); wr = 0; wdata = 0;
    endtask

    task automatic expect_latches(string tag, int exp);
        total++;
        if (latches != exp) begin
            bad++;
            $display("FAIL %s latch_count actual=%0d expected=%0d", tag, latches, exp);
        end
        latches = 0;
    endtask

    initial begin
        step(3);
        phase = "R1"; arst_n = 1;
        step(SPAN + 10);
        expect_latches("R6", 1);

        phase = "R3"; ext_n = 0; step(FILT - 1); ext_n = 1; step(10);
        expect_latches("R3", 0);
        ext_n = 0; step(FILT + 3); ext_n = 1;
        phase = "R4"; flash = 0; step(SPAN + 10);
        flash = 1; step(5);
        expect_latches("R6", 1);

        phase = "R5"; wdt = 1; step(1); wdt = 0;
        step(10); osc = 0; step(8); osc = 1; step(SPAN + 10);
        phase = "R6"; expect_latches("R6", 0);

        phase = "R2"; ext_n = 0; step(FILT + 4); wdt = 1; step(1); wdt = 0;
        ext_n = 1; step(SPAN + 10);
        expect_latches("R6", 1);

        phase = "R7"; pd_write(0); step(3); pd_write(1); step(5);
        phase = "R8";
        for (int i = 0; i < NW; i++) begin
            if (!pd_o) pd_write(1);
            step(3);
            wake[i] = 1; step(1); wake[i] = 0;
            step(SPAN + 8);
        end

        phase = "R9"; wake = 8'hFF; step(2); wake = '0; step(10);

        phase = "R10"; pd_write(1); step(3);
        wr = 1; wdata = 1; wake[3] = 1; step(1); wake[3] = 0;
        step(2); wr = 0; wdata = 0; step(SPAN + 8);
        pd_write(1); step(2);
        wr = 1; wdata = 1; wdt = 1; step(1); wdt = 0; wr = 0; wdata = 0;
        step(SPAN + 10);
        expect_latches("R10", 0);

        phase = "R1"; arst_n = 0; step(3);
        chk("sys_rst_in_reset", rst_o, 1'b1);
        chk("clk_en_in_reset", en_o, 1'b0);
        arst_n = 1; step(SPAN + 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog expired in %s", phase);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule